// File: doc/BRIEF.md
# Dual-Channel Line CRC Checker

This block checks the per-line CRC carried inside a 20-bit high-definition video stream. The stream has two 10-bit lanes, luma and colour-difference. For each lane the block computes a CRC over the words of a line and compares it with the check value that the transmitter placed in that lane just after the line number words. There is one registered error flag per lane. A flag is raised when the two values disagree and cleared when they agree. It keeps that value until the next line's comparison.

Timing reference detection happens upstream. A single strobe marks the last word of every timing reference code, and bit 6 of the luma word in that cycle says which kind of code it is. After a start-of-active-video code, the block starts a fresh CRC on the next word. After an end-of-active-video code, it adds in the two line number words, takes the next two words as the embedded check value, and updates the flags one clock later.

Top module: `lcrc_top`

## Requirements
- R1: Each lane's CRC uses the generator x^18 + x^5 + x^4 + 1. Bits go in least significant first, 10 bits per clock. The CRC is cleared to zero when the strobe is high and luma bit 6 is 0 (start code), so the first word it covers is the next one.
- R2: Accumulation covers every word from the first word after a start code up to and including the strobed end code word (strobe high and luma bit 6 = 1), plus the two words that follow that end code.
- R3: The third and fourth words after the strobed end code carry the embedded CRC. Word bits 8:0 hold CRC bits 8:0 in the third word and CRC bits 17:9 in the fourth word. Bit 9 of these words is not compared.
- R4: One clock after the fourth word, the luma flag is 1 if its computed and embedded CRC differ and 0 if they agree.
- R5: The colour-difference lane is checked on its own words and drives its own flag, independently of the luma result.
- R6: Each flag holds its value between comparisons, including through the whole of the next line.
- R7: While reset is asserted, and after it is released, both flags are 0 and no line is being tracked.
- R8: An end code strobe that does not follow a start code (no line being tracked) starts no comparison, and both flags keep their values.
- R9: A start code that arrives part way through a line discards the partial CRC and restarts accumulation from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| luma_i | input | 10 | Luma lane word |
| chroma_i | input | 10 | Colour-difference lane word |
| trs_stb | input | 1 | High on the last word of a timing reference code; luma bit 6 in that cycle is 1 for an end code and 0 for a start code |
| luma_crc_err | output | 1 | Luma CRC mismatch flag |
| chroma_crc_err | output | 1 | Colour-difference CRC mismatch flag |

## Verification
The hardest case to reach from the ports is a line cut short by a new start code, because the stale partial CRC must disappear without trace. The stimulus sends a start code and a few random words, then a complete line whose check value covers only the second segment. It does this right after a line that raised both flags, so a correct result shows up as both flags falling. An orphan end code followed by random words is also sent while the flags are high, to show that nothing is compared. Several other cases are mixed in among random lines of random length: corruption of single bits in either check word of either lane, flips of the unchecked bit 9, and a line with no active words.

// File: rtl/lcrc_pkg.sv
package lcrc_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ACT  = 3'd1,
        PH_LN0  = 3'd2,
        PH_LN1  = 3'd3,
        PH_CW0  = 3'd4,
        PH_CW1  = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e ph;
    } seq_t;

endpackage

// File: rtl/lcrc_seq.sv
module lcrc_seq
    import lcrc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trs_stb,
    input  logic tag_bit,
    output logic clr_o,
    output logic acc_o,
    output logic cap_o,
    output logic cmp_o
);

    seq_t s_d, s_q;
    logic start_code;

    always_comb begin
        s_d        = s_q;
        clr_o      = 1'b0;
        acc_o      = 1'b0;
        cap_o      = 1'b0;
        cmp_o      = 1'b0;
        start_code = trs_stb && !tag_bit;
        if (start_code) begin
            s_d.ph = PH_ACT;
            clr_o  = 1'b1;
        end else begin
            unique case (s_q.ph)
                PH_ACT: begin
                    acc_o = 1'b1;
                    if (trs_stb) s_d.ph = PH_LN0;
                end
                PH_LN0: begin
                    acc_o  = 1'b1;
                    s_d.ph = PH_LN1;
                end
                PH_LN1: begin
                    acc_o  = 1'b1;
                    s_d.ph = PH_CW0;
                end
                PH_CW0: begin
                    cap_o  = 1'b1;
                    s_d.ph = PH_CW1;
                end
                PH_CW1: begin
                    cmp_o  = 1'b1;
                    s_d.ph = PH_IDLE;
                end
                default: s_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_IDLE};
        else        s_q <= s_d;
    end

    // R2
    ln_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_LN1 && !(trs_stb && !tag_bit)) |=> (s_q.ph == PH_CW0));

    // R8
    orphan_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ph == PH_IDLE && trs_stb && tag_bit) |=> (s_q.ph == PH_IDLE));

    // R9
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trs_stb && !tag_bit) |=> (s_q.ph == PH_ACT));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_o, acc_o, cap_o, cmp_o}));

endmodule

// File: rtl/lcrc_lane.sv
module lcrc_lane #(
    parameter int          DATA_W    = 10,
    parameter int          CRC_W     = 18,
    parameter logic [17:0] POLY_MASK = 18'h23000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_i,
    input  logic              clr_i,
    input  logic              acc_i,
    input  logic              cap_i,
    input  logic              cmp_i,
    output logic              err_o
);

    localparam int HALF_W = CRC_W / 2;

    typedef struct packed {
        logic [CRC_W-1:0]  crc;
        logic [HALF_W-1:0] lo;
        logic              err;
    } lane_t;

    lane_t l_d, l_q;

    function automatic logic [CRC_W-1:0] crc_word(input logic [CRC_W-1:0] c,
                                                  input logic [DATA_W-1:0] d);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = c;
        for (int i = 0; i < DATA_W; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ POLY_MASK[CRC_W-1:0];
        end
        return r;
    endfunction

    logic [CRC_W-1:0] embedded;

    always_comb begin
        l_d      = l_q;
        embedded = {data_i[HALF_W-1:0], l_q.lo};
        if (clr_i)      l_d.crc = '0;
        else if (acc_i) l_d.crc = crc_word(l_q.crc, data_i);
        if (cap_i)      l_d.lo  = data_i[HALF_W-1:0];
        if (cmp_i)      l_d.err = (embedded != l_q.crc);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) l_q <= '0;
        else        l_q <= l_d;
    end

    assign err_o = l_q.err;

    // R1
    crc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (l_q.crc == '0));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_i |=> $stable(l_q.err));

    // R4
    match_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_i && data_i[HALF_W-1:0] == l_q.crc[CRC_W-1:HALF_W]
               && l_q.lo == l_q.crc[HALF_W-1:0]) |=> !l_q.err);

    // R2
    crc_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_i || cmp_i) |=> $stable(l_q.crc));

endmodule

// File: rtl/lcrc_top.sv
module lcrc_top #(
    parameter int DATA_W  = 10,
    parameter int CRC_W   = 18,
    parameter int TAG_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] luma_i,
    input  logic [DATA_W-1:0] chroma_i,
    input  logic              trs_stb,
    output logic              luma_crc_err,
    output logic              chroma_crc_err
);

    localparam int LANES = 2;

    logic clr, acc, cap, cmp;
    logic [LANES-1:0][DATA_W-1:0] lane_data;
    logic [LANES-1:0]             lane_err;

    assign lane_data[0] = luma_i;
    assign lane_data[1] = chroma_i;

    lcrc_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trs_stb (trs_stb),
        .tag_bit (luma_i[TAG_BIT]),
        .clr_o   (clr),
        .acc_o   (acc),
        .cap_o   (cap),
        .cmp_o   (cmp)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lcrc_lane #(
            .DATA_W (DATA_W),
            .CRC_W  (CRC_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .data_i (lane_data[g]),
            .clr_i  (clr),
            .acc_i  (acc),
            .cap_i  (cap),
            .cmp_i  (cmp),
            .err_o  (lane_err[g])
        );
    end

    assign luma_crc_err   = lane_err[0];
    assign chroma_crc_err = lane_err[1];

    // R7
    reset_low_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (!luma_crc_err && !chroma_crc_err));

endmodule

// File: tb/sim_lcrc_top.sv
module sim_lcrc_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] luma = '0, chroma = '0;
    logic       stb = 1'b0;
    logic       luma_err, chroma_err;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [17:0] rl, rc;
    logic exp_l = 0, exp_c = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcrc_top u0 (
        .clk(clk), .rst_n(rst_n), .luma_i(luma), .chroma_i(chroma),
        .trs_stb(stb), .luma_crc_err(luma_err), .chroma_crc_err(chroma_err)
    );

    // Reference written as a non-reflected register fed by bit-reversed state.
    function automatic logic [17:0] ref_step(logic [17:0] c, logic [9:0] d);
        logic [17:0] r, o;
        logic fb;
        for (int i = 0; i < 18; i++) r[i] = c[17-i];
        for (int i = 0; i < 10; i++) begin
            fb = r[17] ^ d[i];
            r  = {r[16:0], 1'b0};
            if (fb) r = r ^ 18'h00031;
        end
        for (int i = 0; i < 18; i++) o[i] = r[17-i];
        return o;
    endfunction

    task automatic check(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", req, got, exp);
        end
    endtask

    task automatic word(logic [9:0] l, logic [9:0] c, logic s);
        luma = l; chroma = c; stb = s;
        @(negedge clk);
    endtask

    task automatic accw(logic [9:0] l, logic [9:0] c, logic s);
        rl = ref_step(rl, l);
        rc = ref_step(rc, c);
        word(l, c, s);
    endtask

    function automatic logic flip_err(int idx);
        return (idx >= 0) && (idx % 10 != 9);
    endfunction

    // fl/fc: -1 no corruption, 0..9 bit of third word, 10..19 bit of fourth word
    task automatic send_line(int n_act, int fl, int fc, string req);
        logic [9:0] w0l, w1l, w0c, w1c;
        word(10'h3FF, 10'h3FF, 0);
        word(10'h000, 10'h000, 0);
        word(10'h000, 10'h000, 0);
        word(10'h280, 10'h280, 1);              // start code, bit 6 = 0
        rl = '0; rc = '0;
        for (int i = 0; i < n_act; i++) begin
            accw(10'($urandom), 10'($urandom), 0);
            if (i == 1) begin                   // R6: hold into next line
                check("R6 luma hold", luma_err, exp_l);
                check("R6 chroma hold", chroma_err, exp_c);
            end
        end
        accw(10'h3FF, 10'h3FF, 0);
        accw(10'h000, 10'h000, 0);
        accw(10'h000, 10'h000, 0);
        accw(10'h2D0, 10'h2D0, 1);              // end code, bit 6 = 1
        accw(10'($urandom), 10'($urandom), 0);  // line number words
        accw(10'($urandom), 10'($urandom), 0);
        w0l = {~rl[8], rl[8:0]};   w1l = {~rl[17], rl[17:9]};
        w0c = {~rc[8], rc[8:0]};   w1c = {~rc[17], rc[17:9]};
        if (fl >= 10) w1l[fl-10] = ~w1l[fl-10]; else if (fl >= 0) w0l[fl] = ~w0l[fl];
        if (fc >= 10) w1c[fc-10] = ~w1c[fc-10]; else if (fc >= 0) w0c[fc] = ~w0c[fc];
        word(w0l, w0c, 0);
        word(w1l, w1c, 0);
        exp_l = flip_err(fl);
        exp_c = flip_err(fc);
        check({req, " luma R4"}, luma_err, exp_l);
        check({req, " chroma R5"}, chroma_err, exp_c);
        for (int i = 0; i < 3; i++) word(10'($urandom), 10'($urandom), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        check("R7 luma reset", luma_err, 1'b0);
        check("R7 chroma reset", chroma_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 luma after reset", luma_err, 1'b0);

        send_line(12, -1, -1, "R1 R2 clean");
        send_line(20, 3, -1, "R3 luma low word");
        send_line(20, -1, 15, "R3 chroma high word");
        send_line(8, 9, 19, "R3 bit9 ignored");
        send_line(0, -1, -1, "R2 empty line");
        send_line(16, 17, 0, "R4 R5 both bad");

        // R8: orphan end code while flags are high
        word(10'h2D0, 10'h2D0, 1);
        for (int i = 0; i < 6; i++) word(10'($urandom), 10'($urandom), 0);
        check("R8 luma orphan", luma_err, 1'b1);
        check("R8 chroma orphan", chroma_err, 1'b1);

        // R9: partial line then restart
        word(10'h280, 10'h280, 1);
        for (int i = 0; i < 5; i++) word(10'($urandom), 10'($urandom), 0);
        send_line(10, -1, -1, "R9 restart");

        for (int k = 0; k < 150; k++) begin
            int fl, fc;
            fl = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 19)) : -1;
            fc = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, 19)) : -1;
            send_line(int'($urandom_range(0, 40)), fl, fc, "R4 R5 random");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule